// File: doc/BRIEF.md
# Character LCD Power-On Sequencer and Write Controller

This block drives a parallel 8-bit character LCD module of the common two-line type. It takes the panel from power-up to a usable state without software help. After reset it waits for the panel's supply to settle. It then sends four fixed setup instructions, with a minimum pause after each, and only then offers a simple request port to the host. Every transfer is a write. The block never reads the panel's busy flag. It waits a fixed, worst-case time after each strobe instead.

The host hands over one byte per valid/ready handshake. A select bit chooses the data register or the instruction register. A second mode takes a row, a column and a character. In that mode the block computes the display-memory address of the cell, issues the set-address instruction and then writes the character, all from one handshake. Every delay, including the enable pulse widths, is derived from a clock-frequency parameter. Each nanosecond figure is rounded up to whole cycles, so a faster or slower system clock never shortens a minimum time.

Top module: `charlcd_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, and in the cycle after, `lcd_e` and `req_ready` are 0 and `lcd_rw` is 0.
- R2: No enable pulse starts before 20 ms worth of clock cycles have passed since reset was released.
- R3: The first four strobes after reset all have `lcd_rs` = 0 and carry, in order: 0x38, display control 0x0C with bit 1 = CURSOR_ON and bit 0 = BLINK_ON, 0x01, and 0x06.
- R4: After the first and second setup strobes the falling edges are at least 37 us apart. After the clear instruction at least 1.52 ms passes before the next strobe. `req_ready` first rises at least 37 us after the last setup strobe.
- R5: A request is taken only in a cycle where `req_valid` and `req_ready` are both 1. `req_ready` is 0 in the next cycle and stays 0 until the transfer and its delay are complete. While `req_ready` is 0, `req_valid` is ignored and causes no strobe.
- R6: In a plain request, `lcd_rs` equals `req_rs` (1 = data register, 0 = instruction register) and `lcd_db` equals `req_byte` at the falling edge of `lcd_e`. `lcd_rw` is always 0.
- R7: `lcd_e` stays high for at least 220 ns. `lcd_rs` and `lcd_db` are stable for at least one cycle (and at least 40 ns) before `lcd_e` rises, throughout the high phase, and for at least one cycle (and at least 10 ns) after it falls. `lcd_e` is never high while `req_ready` is 1.
- R8: An instruction byte of 0x01, 0x02 or 0x03 (bits 7..2 zero, bits 1..0 nonzero) is followed by at least 1.52 ms before `req_ready` returns. Every other transfer is followed by at least 37 us.
- R9: With `req_goto` = 1, two strobes are issued 37 us or more apart. The first has RS = 0 and byte 0x80 | addr, where addr = column for row 0 and 0x40 + column for row 1, and a column above 39 is treated as 39. The second has RS = 1 and byte `req_byte`.
- R10: Each delay in cycles is ceil(t_ns x CLK_HZ / 1e9), and at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock of CLK_HZ hertz |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host offers a request |
| req_ready | output | 1 | Block can take a request this cycle |
| req_rs | input | 1 | 1 = data register, 0 = instruction register (plain mode) |
| req_byte | input | 8 | Byte to write, or character in positioned mode |
| req_goto | input | 1 | 1 = positioned write using row and column |
| req_row | input | 1 | Display row for a positioned write |
| req_col | input | COL_W | Display column for a positioned write |
| lcd_rs | output | 1 | Register select to the panel |
| lcd_rw | output | 1 | Read/write select, held at write |
| lcd_e | output | 1 | Enable strobe; the panel latches on its fall |
| lcd_db | output | 8 | Data bus to the panel |

## Verification
The bound checker watches the strobe on every cycle. It checks the high width, the stability of RS and the data around both edges, that E never overlaps ready, the handshake drop after an accept, and the power-on and post-strobe minimum gaps. The bench scenarios show what a cycle-local property cannot. These are the exact order and contents of the four setup instructions, the long pause after the clear, the choice between the long and short delay by instruction value, the address arithmetic and column clamp of positioned writes, and that requests offered while busy leave no trace on the bus.

// File: rtl/charlcd_pkg.sv
// Package: shared state types, cycle arithmetic and setup instruction table
// for the character LCD controller. Assumes delays are given in nanoseconds.
package charlcd_pkg;

    typedef enum logic [2:0] {
        ST_BOOT,
        ST_PWR,
        ST_ISSUE,
        ST_STROBE,
        ST_WAIT,
        ST_IDLE
    } seq_state_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_HIGH,
        PH_HOLD
    } strobe_phase_t;

    // Minimum times in nanoseconds
    localparam longint unsigned T_POWERON_NS = 64'd20_000_000;
    localparam longint unsigned T_SHORT_NS   = 64'd37_000;
    localparam longint unsigned T_LONG_NS    = 64'd1_520_000;
    localparam longint unsigned T_SETUP_NS   = 64'd40;
    localparam longint unsigned T_EHIGH_NS   = 64'd220;
    localparam longint unsigned T_HOLD_NS    = 64'd10;

    // Round a time up to whole clock cycles, never returning zero
    function automatic int unsigned ns_to_cycles(input longint unsigned ns,
                                                 input longint unsigned hz);
        longint unsigned c;
        c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
        if (c == 0) c = 1;
        return 32'(c);
    endfunction

    // Setup instruction for step idx of the power-on sequence
    function automatic logic [7:0] setup_cmd(input logic [1:0] idx,
                                             input logic cursor_on,
                                             input logic blink_on);
        case (idx)
            2'd0:    return 8'h38;
            2'd1:    return {6'b000011, cursor_on, blink_on};
            2'd2:    return 8'h01;
            default: return 8'h06;
        endcase
    endfunction

    // True for clear and return-home instructions, which need the long delay
    function automatic logic needs_long(input logic rs, input logic [7:0] b);
        return (!rs) && (b[7:2] == 6'd0) && (b[1:0] != 2'd0);
    endfunction

endpackage

// File: rtl/charlcd_delay.sv
// Down-counting delay timer. A load sets the count; expired is high once the
// count has reached zero. Assumes load is not held across the waiting period.
module charlcd_delay #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] value,
    output logic         expired
);

    logic [W-1:0] cnt;

    // Count down to zero after each load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= value;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/charlcd_strobe.sv
// Enable strobe engine. On start it captures RS and the byte, holds them with
// E low for SU_CYC cycles, raises E for HI_CYC cycles, keeps lines steady for
// HOLD_CYC cycles after the fall, then pulses done. The lines keep their
// values until the next start. Assumes start only while idle.
module charlcd_strobe
    import charlcd_pkg::*;
#(
    parameter int unsigned SU_CYC   = 1,
    parameter int unsigned HI_CYC   = 1,
    parameter int unsigned HOLD_CYC = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       rs_in,
    input  logic [7:0] db_in,
    output logic       e,
    output logic       rs,
    output logic [7:0] db,
    output logic       done
);

    localparam int unsigned MAX_A = (SU_CYC > HI_CYC) ? SU_CYC : HI_CYC;
    localparam int unsigned MAX_C = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
    localparam int CW = (MAX_C < 2) ? 1 : $clog2(MAX_C);

    strobe_phase_t phase;
    logic [CW-1:0] cnt;

    // Walk setup, high and hold phases with a shared cycle counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            rs    <= 1'b0;
            db    <= 8'h00;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        rs    <= rs_in;
                        db    <= db_in;
                        cnt   <= CW'(SU_CYC - 1);
                        phase <= PH_SETUP;
                    end
                end
                PH_SETUP: begin
                    if (cnt == '0) begin
                        cnt   <= CW'(HI_CYC - 1);
                        phase <= PH_HIGH;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (cnt == '0) begin
                        cnt   <= CW'(HOLD_CYC - 1);
                        phase <= PH_HOLD;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    if (cnt == '0) begin
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
            endcase
        end
    end

    assign e = (phase == PH_HIGH);

endmodule

// File: rtl/charlcd_goto.sv
// Cell address encoder. Maps a row and column onto the panel's display memory
// (row 0 from 0x00, row 1 from 0x40) and forms the set-address instruction.
// Columns past the last memory cell of a row are clamped to it.
module charlcd_goto #(
    parameter int LINE_LEN = 40,
    parameter int COL_W    = 6
) (
    input  logic             row,
    input  logic [COL_W-1:0] col,
    output logic [7:0]       cmd
);

    localparam logic [COL_W-1:0] LAST_COL = COL_W'(LINE_LEN - 1);

    logic [COL_W-1:0] col_eff;
    logic [6:0]       addr;

    // Clamp the column and add the row base
    always_comb begin
        col_eff = (col > LAST_COL) ? LAST_COL : col;
        addr    = {row, 6'd0} + 7'(col_eff);
        cmd     = {1'b1, addr};
    end

endmodule

// File: rtl/charlcd_ctrl.sv
// Character LCD controller top. Runs the timed power-on setup sequence, then
// serves host writes (plain or row/column positioned) through a valid/ready
// port. Every wait is a fixed worst-case delay computed from CLK_HZ; the
// panel's busy flag is never read. Assumes rst_n is synchronous to clk.
module charlcd_ctrl
    import charlcd_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 50_000_000,
    parameter bit          CURSOR_ON = 1'b0,
    parameter bit          BLINK_ON  = 1'b0,
    parameter int          LINE_LEN  = 40,
    parameter int          COL_W     = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_rs,
    input  logic [7:0]       req_byte,
    input  logic             req_goto,
    input  logic             req_row,
    input  logic [COL_W-1:0] req_col,
    output logic             lcd_rs,
    output logic             lcd_rw,
    output logic             lcd_e,
    output logic [7:0]       lcd_db
);

    localparam longint unsigned HZ = 64'(CLK_HZ);
    localparam int unsigned PON_CYC   = ns_to_cycles(T_POWERON_NS, HZ);
    localparam int unsigned SHORT_CYC = ns_to_cycles(T_SHORT_NS, HZ);
    localparam int unsigned LONG_CYC  = ns_to_cycles(T_LONG_NS, HZ);
    localparam int unsigned SU_CYC    = ns_to_cycles(T_SETUP_NS, HZ);
    localparam int unsigned HI_CYC    = ns_to_cycles(T_EHIGH_NS, HZ);
    localparam int unsigned HOLD_CYC  = ns_to_cycles(T_HOLD_NS, HZ);
    localparam int TW = $clog2(PON_CYC + 1);

    seq_state_t   st;
    logic [1:0]   init_idx;
    logic         in_init;
    logic         cur_rs;
    logic [7:0]   cur_byte;
    logic         pend;
    logic [7:0]   pend_byte;

    logic         tmr_load;
    logic [TW-1:0] tmr_val;
    logic         tmr_expired;
    logic         stb_start;
    logic         stb_done;
    logic [7:0]   goto_cmd;

    // Delay timer shared by the power-on wait and every post-strobe wait
    charlcd_delay #(.W(TW)) u_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .value   (tmr_val),
        .expired (tmr_expired)
    );

    // Enable strobe generator
    charlcd_strobe #(
        .SU_CYC   (SU_CYC),
        .HI_CYC   (HI_CYC),
        .HOLD_CYC (HOLD_CYC)
    ) u_strobe (
        .clk   (clk),
        .rst_n (rst_n),
        .start (stb_start),
        .rs_in (cur_rs),
        .db_in (cur_byte),
        .e     (lcd_e),
        .rs    (lcd_rs),
        .db    (lcd_db),
        .done  (stb_done)
    );

    // Row/column to set-address instruction
    charlcd_goto #(.LINE_LEN(LINE_LEN), .COL_W(COL_W)) u_goto (
        .row (req_row),
        .col (req_col),
        .cmd (goto_cmd)
    );

    // Timer loads and strobe start derived from the current state
    always_comb begin
        tmr_load  = 1'b0;
        tmr_val   = '0;
        stb_start = 1'b0;
        case (st)
            ST_BOOT: begin
                tmr_load = 1'b1;
                tmr_val  = TW'(PON_CYC);
            end
            ST_ISSUE: stb_start = 1'b1;
            ST_STROBE: begin
                if (stb_done) begin
                    tmr_load = 1'b1;
                    tmr_val  = needs_long(cur_rs, cur_byte) ? TW'(LONG_CYC)
                                                             : TW'(SHORT_CYC);
                end
            end
            default: ;
        endcase
    end

    // Sequencer: power-on wait, setup steps, then host transfers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_BOOT;
            init_idx  <= 2'd0;
            in_init   <= 1'b1;
            cur_rs    <= 1'b0;
            cur_byte  <= 8'h00;
            pend      <= 1'b0;
            pend_byte <= 8'h00;
        end else begin
            case (st)
                ST_BOOT: st <= ST_PWR;
                ST_PWR: begin
                    if (tmr_expired) begin
                        cur_rs   <= 1'b0;
                        cur_byte <= setup_cmd(2'd0, CURSOR_ON, BLINK_ON);
                        st       <= ST_ISSUE;
                    end
                end
                ST_ISSUE: st <= ST_STROBE;
                ST_STROBE: begin
                    if (stb_done) st <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (tmr_expired) begin
                        if (in_init) begin
                            if (init_idx == 2'd3) begin
                                in_init <= 1'b0;
                                st      <= ST_IDLE;
                            end else begin
                                init_idx <= init_idx + 2'd1;
                                cur_byte <= setup_cmd(init_idx + 2'd1,
                                                      CURSOR_ON, BLINK_ON);
                                st       <= ST_ISSUE;
                            end
                        end else if (pend) begin
                            pend     <= 1'b0;
                            cur_rs   <= 1'b1;
                            cur_byte <= pend_byte;
                            st       <= ST_ISSUE;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end
                ST_IDLE: begin
                    if (req_valid) begin
                        if (req_goto) begin
                            cur_rs    <= 1'b0;
                            cur_byte  <= goto_cmd;
                            pend      <= 1'b1;
                            pend_byte <= req_byte;
                        end else begin
                            cur_rs   <= req_rs;
                            cur_byte <= req_byte;
                        end
                        st <= ST_ISSUE;
                    end
                end
                default: st <= ST_BOOT;
            endcase
        end
    end

    assign req_ready = (st == ST_IDLE);
    assign lcd_rw    = 1'b0;

endmodule

// File: rtl/charlcd_ctrl_chk.sv
// Protocol checker for charlcd_ctrl, attached by bind. Counters measure the
// enable high width, the low time since the last fall and the time since
// reset release; properties compare them with the cycle minimums.
module charlcd_ctrl_chk
    import charlcd_pkg::*;
#(
    parameter int unsigned CLK_HZ = 50_000_000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       lcd_rs,
    input logic       lcd_e,
    input logic [7:0] lcd_db
);

    localparam longint unsigned HZ = 64'(CLK_HZ);
    localparam int unsigned PON_CYC   = ns_to_cycles(T_POWERON_NS, HZ);
    localparam int unsigned SHORT_CYC = ns_to_cycles(T_SHORT_NS, HZ);
    localparam int unsigned HI_CYC    = ns_to_cycles(T_EHIGH_NS, HZ);

    logic [31:0] hi_cnt;
    logic [31:0] lo_cnt;
    logic [31:0] since_rst;
    logic        seen_e;

    // Measure high width, low time and age since reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt    <= '0;
            lo_cnt    <= '0;
            since_rst <= '0;
            seen_e    <= 1'b0;
        end else begin
            hi_cnt <= lcd_e ? hi_cnt + 32'd1 : 32'd0;
            if (lcd_e) lo_cnt <= '0;
            else if (lo_cnt != 32'hFFFF_FFFF) lo_cnt <= lo_cnt + 32'd1;
            if (since_rst != 32'hFFFF_FFFF) since_rst <= since_rst + 32'd1;
            if (lcd_e) seen_e <= 1'b1;
        end
    end

    assert_no_early_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(lcd_e) && !seen_e) |-> (since_rst >= PON_CYC));

    assert_accept_drops_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_no_e_while_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !lcd_e);

    assert_setup_before_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lcd_e) |-> ($stable(lcd_rs) && $stable(lcd_db)));

    assert_stable_while_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_e && $past(lcd_e)) |-> ($stable(lcd_rs) && $stable(lcd_db)));

    assert_hold_after_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lcd_e) |=> ($stable(lcd_rs) && $stable(lcd_db)));

    assert_e_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lcd_e) |-> (hi_cnt >= HI_CYC));

    assert_min_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(req_ready) && seen_e) |-> (lo_cnt >= SHORT_CYC));

endmodule

bind charlcd_ctrl charlcd_ctrl_chk #(.CLK_HZ(CLK_HZ)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .lcd_rs    (lcd_rs),
    .lcd_e     (lcd_e),
    .lcd_db    (lcd_db)
);

// File: tb/tb_charlcd_ctrl.sv
// Bench for charlcd_ctrl: checks the setup sequence and its timing, then walks
// a table of host requests, then directed reset and busy-request cases.
module tb_charlcd_ctrl;

    localparam int unsigned CLK_HZ = 4_000_000;
    localparam int COL_W = 6;
    // Expected cycle minimums: ceil(ns * 4 MHz / 1e9)
    localparam int PON   = 80000;
    localparam int SHORT = 148;
    localparam int LONG  = 6080;
    localparam int SLACK = 16;

    typedef struct packed {
        logic       go;
        logic       rs;
        logic       row;
        logic [5:0] col;
        logic [7:0] byt;
        logic [1:0] n;
        logic [7:0] b0;
        logic       r0;
        logic [7:0] b1;
        logic       lng;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 1'b0, 6'd0,  8'h41, 2'd1, 8'h41, 1'b1, 8'h00, 1'b0},
        '{1'b0, 1'b0, 1'b0, 6'd0,  8'h01, 2'd1, 8'h01, 1'b0, 8'h00, 1'b1},
        '{1'b0, 1'b0, 1'b0, 6'd0,  8'h02, 2'd1, 8'h02, 1'b0, 8'h00, 1'b1},
        '{1'b0, 1'b0, 1'b0, 6'd0,  8'h03, 2'd1, 8'h03, 1'b0, 8'h00, 1'b1},
        '{1'b0, 1'b0, 1'b0, 6'd0,  8'h04, 2'd1, 8'h04, 1'b0, 8'h00, 1'b0},
        '{1'b0, 1'b0, 1'b0, 6'd0,  8'h0C, 2'd1, 8'h0C, 1'b0, 8'h00, 1'b0},
        '{1'b1, 1'b1, 1'b0, 6'd5,  8'h5A, 2'd2, 8'h85, 1'b0, 8'h5A, 1'b0},
        '{1'b1, 1'b0, 1'b1, 6'd0,  8'h30, 2'd2, 8'hC0, 1'b0, 8'h30, 1'b0},
        '{1'b1, 1'b0, 1'b1, 6'd39, 8'h21, 2'd2, 8'hE7, 1'b0, 8'h21, 1'b0},
        '{1'b1, 1'b0, 1'b0, 6'd50, 8'h7E, 2'd2, 8'hA7, 1'b0, 8'h7E, 1'b0},
        '{1'b0, 1'b1, 1'b0, 6'd0,  8'hFF, 2'd1, 8'hFF, 1'b1, 8'h00, 1'b0}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic             req_rs = 1'b0;
    logic [7:0]       req_byte = 8'h00;
    logic             req_goto = 1'b0;
    logic             req_row = 1'b0;
    logic [COL_W-1:0] req_col = '0;
    logic             lcd_rs;
    logic             lcd_rw;
    logic             lcd_e;
    logic [7:0]       lcd_db;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 0;

    logic       log_rs [32];
    logic [7:0] log_db [32];
    int         log_t  [32];
    int         nlog = 0;
    logic       prev_e = 1'b0;

    charlcd_ctrl #(
        .CLK_HZ    (CLK_HZ),
        .CURSOR_ON (1'b1),
        .BLINK_ON  (1'b0),
        .COL_W     (COL_W)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_rs    (req_rs),
        .req_byte  (req_byte),
        .req_goto  (req_goto),
        .req_row   (req_row),
        .req_col   (req_col),
        .lcd_rs    (lcd_rs),
        .lcd_rw    (lcd_rw),
        .lcd_e     (lcd_e),
        .lcd_db    (lcd_db)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Log RS and bus at every falling edge of E, sampled between clock edges
    always @(negedge clk) begin
        if (prev_e && !lcd_e && nlog < 32) begin
            log_rs[nlog] = lcd_rs;
            log_db[nlog] = lcd_db;
            log_t[nlog]  = cyc;
            nlog = nlog + 1;
        end
        prev_e = lcd_e;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_ready(output int at);
        while (!req_ready) @(negedge clk);
        at = cyc;
    endtask

    task automatic finish_run();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        int rel;
        int rdy;
        int base;
        repeat (5) @(negedge clk);
        // R1: reset state
        check(lcd_e == 1'b0, "R1 e in reset", int'(lcd_e), 0);
        check(req_ready == 1'b0, "R1 ready in reset", int'(req_ready), 0);
        check(lcd_rw == 1'b0, "R1 rw in reset", int'(lcd_rw), 0);
        rst_n = 1'b1;
        repeat (1000) @(negedge clk);
        // R2: nothing strobed early in the power-on wait
        check(nlog == 0 && !lcd_e, "R2 early strobe", nlog, 0);
        // R1: reset again mid-wait
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!lcd_e && !req_ready, "R1 second reset", int'({lcd_e, req_ready}), 0);
        nlog = 0;
        rst_n = 1'b1;
        @(negedge clk);
        check(!req_ready && !lcd_e && !lcd_rw, "R1 after release",
              int'({req_ready, lcd_e, lcd_rw}), 0);
        rel = cyc;
        wait_ready(rdy);
        @(negedge clk);
        // R3: setup contents
        check(nlog == 4, "R3 setup count", nlog, 4);
        check(log_db[0] == 8'h38 && !log_rs[0], "R3 step0", int'({log_rs[0], log_db[0]}), 'h38);
        check(log_db[1] == 8'h0E && !log_rs[1], "R3 step1", int'({log_rs[1], log_db[1]}), 'h0E);
        check(log_db[2] == 8'h01 && !log_rs[2], "R3 step2", int'({log_rs[2], log_db[2]}), 'h01);
        check(log_db[3] == 8'h06 && !log_rs[3], "R3 step3", int'({log_rs[3], log_db[3]}), 'h06);
        // R2 / R10: power-on delay
        check(log_t[0] - rel >= PON, "R2 power-on wait", log_t[0] - rel, PON);
        // R4 / R10: setup gaps
        check(log_t[1] - log_t[0] >= SHORT, "R4 gap0", log_t[1] - log_t[0], SHORT);
        check(log_t[2] - log_t[1] >= SHORT, "R4 gap1", log_t[2] - log_t[1], SHORT);
        check(log_t[3] - log_t[2] >= LONG, "R4 clear gap", log_t[3] - log_t[2], LONG);
        check(rdy - log_t[3] >= SHORT, "R4 ready gap", rdy - log_t[3], SHORT);

        // Table of host requests
        for (int i = 0; i < NV; i++) begin
            int dly;
            base = nlog;
            req_goto  = VECS[i].go;
            req_rs    = VECS[i].rs;
            req_row   = VECS[i].row;
            req_col   = VECS[i].col;
            req_byte  = VECS[i].byt;
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            // R5: ready drops after accept
            check(!req_ready, "R5 ready drop", int'(req_ready), 0);
            wait_ready(rdy);
            @(negedge clk);
            check(nlog - base == int'(VECS[i].n), "R6 strobe count", nlog - base, int'(VECS[i].n));
            check(log_db[base] == VECS[i].b0 && log_rs[base] == VECS[i].r0,
                  VECS[i].go ? "R9 address byte" : "R6 byte and rs",
                  int'({log_rs[base], log_db[base]}), int'({VECS[i].r0, VECS[i].b0}));
            if (VECS[i].n == 2'd2) begin
                check(log_db[base+1] == VECS[i].b1 && log_rs[base+1],
                      "R9 char byte", int'({log_rs[base+1], log_db[base+1]}),
                      int'({1'b1, VECS[i].b1}));
                check(log_t[base+1] - log_t[base] >= SHORT, "R9 gap",
                      log_t[base+1] - log_t[base], SHORT);
            end
            dly = VECS[i].lng ? LONG : SHORT;
            check(rdy - log_t[nlog-1] >= dly && rdy - log_t[nlog-1] <= dly + SLACK,
                  VECS[i].lng ? "R8 long delay" : "R10 short delay",
                  rdy - log_t[nlog-1], dly);
            check(lcd_rw == 1'b0, "R6 rw low", int'(lcd_rw), 0);
        end

        // R5: request offered while busy is ignored
        base = nlog;
        req_goto = 1'b0; req_rs = 1'b1; req_byte = 8'h55; req_valid = 1'b1;
        @(negedge clk);
        req_byte = 8'hAA;
        repeat (40) @(negedge clk);
        req_valid = 1'b0;
        wait_ready(rdy);
        @(negedge clk);
        check(nlog - base == 1, "R5 busy ignored count", nlog - base, 1);
        check(log_db[base] == 8'h55, "R5 busy ignored byte", int'(log_db[base]), 'h55);
        repeat (SHORT + 20) @(negedge clk);
        check(nlog - base == 1 && req_ready, "R5 no late strobe", nlog - base, 1);

        finish_run();
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (195000) @(posedge clk);
        if (!finished) begin
            @(negedge clk);
            check(1'b0, "watchdog expired", cyc, 0);
            finish_run();
        end
    end

endmodule